// File: doc/BRIEF.md
# Root Hub Port Status Register Bank

This block holds the status and control word of each downstream port on the root hub of a frame-scheduled USB host controller. Each port has one 16-bit word. Software updates the word with register writes. The device-side logic reports attach events, with a low-speed flag, and detach events. The block merges the two sources each cycle, so that no hardware change indication is lost to a software clear.

Software reads a word by port index. An index past the last implemented port returns a fixed "no port here" pattern. When software moves a port's reset bit from 0 to 1 on a port with a device present, the block raises a one-cycle bus-reset request toward that device.

The block also drives three per-port flags: connected, enabled, and a forward qualifier. The transaction engine uses the forward qualifier to decide whether traffic may go to that port. A controller-wide reset clears every word. It then re-announces any device still plugged in, as if it had just attached.

Top module: `hub_port_bank`

## Requirements
- R1: After `rst_n` is asserted, every port word reads 0x0000. All device-presence state is cleared, and `bus_reset_req`, `port_connected`, `port_enabled` and `port_forward` are all 0.
- R2: A write to a port keeps the old value of bits 0, 1, 3, 4, 5, 6, 7 and 8 (mask 0x01FB). Bits 2 and 9 to 15 take the written value.
- R3: After the merge of R2, a 1 written to bit 1 (connect change) or bit 3 (enable change) clears that bit. A 0 leaves it unchanged.
- R4: `bus_reset_req[i]` is high for exactly one cycle, in the cycle after the write edge. It fires only when the write sets bit 9 (port reset), bit 9 was 0 before, and a device is present. Rewriting bit 9 as 1 while it is already 1 gives no pulse.
- R5: An attach sets bit 0 (connected) and bit 1 (connect change), and sets bit 8 equal to the low-speed flag.
- R6: A detach on a port with a device present does two things. It clears bit 0 and sets bit 1 if bit 0 was set. It clears bit 2 (enable) and sets bit 3 if bit 2 was set. Bit 8 is unchanged. A detach on an empty port changes nothing.
- R7: An attach on a port that already has a device first applies the detach effects of R6, then the attach effects of R5.
- R8: When a write and a device event hit the same port in the same cycle, the write is merged first and the event second. A change bit set by the event therefore survives a write-1-to-clear in that cycle.
- R9: `rd_data` shows the word of the port selected by `rd_idx` in the same cycle. An index of `NUM_PORTS` or more returns 0xFF7F.
- R10: `port_connected[i]` equals bit 0 and `port_enabled[i]` equals bit 2 of port i's word. `port_forward[i]` is 1 only when a device is present and bit 2 is set.
- R11: A `ctrl_reset` cycle sets every word to 0x0000, then replays the attach for each port with a device present: bits 0 and 1 set, bit 8 from that device's stored speed. Writes and device events in that cycle are dropped, and no bus-reset pulse results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reset | input | 1 | Controller-wide reset with attach replay |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Port index of the write |
| wr_data | input | 16 | Write data |
| rd_idx | input | IDX_W | Port index of the read |
| rd_data | output | 16 | Read data |
| dev_attach | input | NUM_PORTS | Per-port attach event pulse |
| dev_low_speed | input | NUM_PORTS | Low-speed flag, qualified by dev_attach |
| dev_detach | input | NUM_PORTS | Per-port detach event pulse |
| bus_reset_req | output | NUM_PORTS | One-cycle bus-reset request per port |
| port_connected | output | NUM_PORTS | Current connect status per port |
| port_enabled | output | NUM_PORTS | Enable status per port |
| port_forward | output | NUM_PORTS | Device present and enabled |

## Verification
The assertions take the event inputs to be single-cycle pulses sampled at the clock edge. They also take `dev_low_speed` to matter only while `dev_attach` is high. Their properties that refer to the past guard each antecedent on the absence of a competing `ctrl_reset`, attach or detach in the same cycle.

The stimulus drives every input on the falling edge and holds it for exactly one rising edge. Each event is therefore seen once. The same-cycle collisions (write with attach, write with controller reset, attach on an occupied port) are applied on purpose, so that the ordering rules are exercised rather than assumed.

// File: rtl/hub_port_pkg.sv
package hub_port_pkg;

    localparam int PSC_W = 16;

    // bit positions inside a port word
    localparam int B_CONN     = 0;
    localparam int B_CONN_CHG = 1;
    localparam int B_EN       = 2;
    localparam int B_EN_CHG   = 3;
    localparam int B_LOW      = 8;
    localparam int B_PRST     = 9;

    localparam logic [PSC_W-1:0] KEEP_MASK  = 16'h01FB;
    localparam logic [PSC_W-1:0] CLR1_MASK  = 16'h000A;
    localparam logic [PSC_W-1:0] ABSENT_VAL = 16'hFF7F;

    typedef struct packed {
        logic [PSC_W-1:0] psc;      // visible port word
        logic             present;  // a device sits on the port
        logic             low;      // speed of that device
        logic             rst_req;  // bus reset request pulse
    } port_state_t;

    // software write: preserve masked bits, then write-one-to-clear
    function automatic logic [PSC_W-1:0] merge_write(input logic [PSC_W-1:0] old_v,
                                                      input logic [PSC_W-1:0] wdata);
        logic [PSC_W-1:0] r;
        r = (old_v & KEEP_MASK) | (wdata & ~KEEP_MASK);
        r = r & ~(wdata & CLR1_MASK);
        return r;
    endfunction

    // device removal effects on the word
    function automatic logic [PSC_W-1:0] drop_device(input logic [PSC_W-1:0] v);
        logic [PSC_W-1:0] r;
        r = v;
        if (v[B_CONN]) begin
            r[B_CONN]     = 1'b0;
            r[B_CONN_CHG] = 1'b1;
        end
        if (v[B_EN]) begin
            r[B_EN]     = 1'b0;
            r[B_EN_CHG] = 1'b1;
        end
        return r;
    endfunction

    // device arrival effects on the word
    function automatic logic [PSC_W-1:0] join_device(input logic [PSC_W-1:0] v,
                                                      input logic             low);
        logic [PSC_W-1:0] r;
        r = v;
        r[B_CONN]     = 1'b1;
        r[B_CONN_CHG] = 1'b1;
        r[B_LOW]      = low;
        return r;
    endfunction

endpackage

// File: rtl/hub_port_reg.sv
module hub_port_reg
    import hub_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_reset,
    input  logic             wr_hit,
    input  logic [PSC_W-1:0] wr_data,
    input  logic             attach,
    input  logic             attach_low,
    input  logic             detach,
    output logic [PSC_W-1:0] psc,
    output logic             present,
    output logic             rst_req
);

    port_state_t st_d, st_q;
    logic        seen_q;

    always_comb begin
        st_d         = st_q;
        st_d.rst_req = 1'b0;
        if (ctrl_reset) begin
            st_d.psc = '0;
            if (st_q.present) begin
                st_d.psc = join_device('0, st_q.low);
            end
        end else begin
            if (wr_hit) begin
                st_d.psc     = merge_write(st_q.psc, wr_data);
                st_d.rst_req = wr_data[B_PRST] & ~st_q.psc[B_PRST] & st_q.present;
            end
            // a removal, or an arrival on an occupied port, drops the old device
            if ((detach || attach) && st_q.present) begin
                st_d.psc     = drop_device(st_d.psc);
                st_d.present = 1'b0;
            end
            if (attach) begin
                st_d.psc     = join_device(st_d.psc, attach_low);
                st_d.present = 1'b1;
                st_d.low     = attach_low;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            seen_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            seen_q <= 1'b1;
        end
    end

    assign psc     = st_q.psc;
    assign present = st_q.present;
    assign rst_req = st_q.rst_req;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |=> !st_q.rst_req);                                             // R4
    AST_PULSE_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.rst_req |-> (st_q.psc[B_PRST] && st_q.present));                        // R4
    AST_CLR1_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(wr_hit && wr_data[B_CONN_CHG] && !attach && !detach && !ctrl_reset))
        |-> !st_q.psc[B_CONN_CHG]);                                                  // R3
    AST_KEEP_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(wr_hit && !attach && !detach && !ctrl_reset))
        |-> (st_q.psc[B_LOW] == $past(st_q.psc[B_LOW]) &&
             st_q.psc[B_CONN] == $past(st_q.psc[B_CONN])));                          // R2
    AST_ATTACH_CONN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(attach && !ctrl_reset))
        |-> (st_q.psc[B_CONN] && st_q.psc[B_CONN_CHG] &&
             st_q.psc[B_LOW] == $past(attach_low)));                                 // R5
    AST_DETACH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(detach && !attach && !ctrl_reset && st_q.present))
        |-> (!st_q.psc[B_CONN] && !st_q.psc[B_EN] && st_q.psc[B_CONN_CHG]));         // R6
    AST_CONN_TRACKS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.psc[B_CONN] == st_q.present);                                           // R10
    AST_CTRL_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen_q && $past(ctrl_reset))
        |-> (!st_q.rst_req && !st_q.psc[B_EN] && !st_q.psc[B_PRST]));                // R11

endmodule

// File: rtl/hub_port_rdmux.sv
module hub_port_rdmux
    import hub_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IDX_W     = 4
) (
    input  logic [NUM_PORTS*PSC_W-1:0] words,
    input  logic [IDX_W-1:0]           rd_idx,
    output logic [PSC_W-1:0]           rd_data
);

    always_comb begin
        rd_data = ABSENT_VAL;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = words[i*PSC_W +: PSC_W];
            end
        end
    end

endmodule

// File: rtl/hub_port_bank.sv
module hub_port_bank
    import hub_port_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_reset,
    input  logic                 wr_en,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [15:0]          wr_data,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [15:0]          rd_data,
    input  logic [NUM_PORTS-1:0] dev_attach,
    input  logic [NUM_PORTS-1:0] dev_low_speed,
    input  logic [NUM_PORTS-1:0] dev_detach,
    output logic [NUM_PORTS-1:0] bus_reset_req,
    output logic [NUM_PORTS-1:0] port_connected,
    output logic [NUM_PORTS-1:0] port_enabled,
    output logic [NUM_PORTS-1:0] port_forward
);

    localparam int WORDS_W = NUM_PORTS * PSC_W;

    logic [WORDS_W-1:0]   words;
    logic [NUM_PORTS-1:0] present;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        logic [PSC_W-1:0] psc_w;
        logic             wr_hit;

        assign wr_hit = wr_en && (wr_idx == IDX_W'(i));

        hub_port_reg u_reg (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctrl_reset (ctrl_reset),
            .wr_hit     (wr_hit),
            .wr_data    (wr_data),
            .attach     (dev_attach[i]),
            .attach_low (dev_low_speed[i]),
            .detach     (dev_detach[i]),
            .psc        (psc_w),
            .present    (present[i]),
            .rst_req    (bus_reset_req[i])
        );

        assign words[i*PSC_W +: PSC_W] = psc_w;
        assign port_connected[i]       = psc_w[B_CONN];
        assign port_enabled[i]         = psc_w[B_EN];
        assign port_forward[i]         = present[i] & psc_w[B_EN];

        AST_FWD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            port_forward[i] |-> (port_connected[i] && port_enabled[i]));             // R10
        AST_NO_PULSE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
            bus_reset_req[i] |-> port_connected[i]);                                 // R4
    end

    hub_port_rdmux #(
        .NUM_PORTS (NUM_PORTS),
        .IDX_W     (IDX_W)
    ) u_rdmux (
        .words   (words),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

endmodule

// File: tb/sim_hub_port_bank.sv
module sim_hub_port_bank;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int IW = 4;
    localparam int NVEC = 14;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          ctrl_reset;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic [15:0]   wr_data;
    logic [IW-1:0] rd_idx;
    logic [15:0]   rd_data;
    logic [NP-1:0] dev_attach, dev_low_speed, dev_detach;
    logic [NP-1:0] bus_reset_req, port_connected, port_enabled, port_forward;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hub_port_bank #(.NUM_PORTS(NP), .IDX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_reset(ctrl_reset),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .dev_attach(dev_attach), .dev_low_speed(dev_low_speed), .dev_detach(dev_detach),
        .bus_reset_req(bus_reset_req), .port_connected(port_connected),
        .port_enabled(port_enabled), .port_forward(port_forward)
    );

    // {wr_en, wr_idx, wr_data, attach, low, detach, exp_p0, exp_p1, exp_rr, exp_fwd}
    localparam logic [62:0] VEC [0:NVEC-1] = '{
        {1'b0, 4'd0, 16'h0000, 2'b01, 2'b01, 2'b00, 16'h0103, 16'h0000, 2'b00, 2'b00}, // R5 low attach
        {1'b0, 4'd0, 16'h0000, 2'b10, 2'b00, 2'b00, 16'h0103, 16'h0003, 2'b00, 2'b00}, // R5 full attach
        {1'b1, 4'd0, 16'h0006, 2'b00, 2'b00, 2'b00, 16'h0105, 16'h0003, 2'b00, 2'b01}, // R2 R3 enable
        {1'b1, 4'd0, 16'h0204, 2'b00, 2'b00, 2'b00, 16'h0305, 16'h0003, 2'b01, 2'b01}, // R4 pulse
        {1'b1, 4'd0, 16'h0004, 2'b00, 2'b00, 2'b00, 16'h0105, 16'h0003, 2'b00, 2'b01}, // R4 release
        {1'b1, 4'd0, 16'h0204, 2'b00, 2'b00, 2'b00, 16'h0305, 16'h0003, 2'b01, 2'b01}, // R4 second edge
        {1'b1, 4'd0, 16'h0204, 2'b00, 2'b00, 2'b00, 16'h0305, 16'h0003, 2'b00, 2'b01}, // R4 held high
        {1'b0, 4'd0, 16'h0000, 2'b00, 2'b00, 2'b01, 16'h030A, 16'h0003, 2'b00, 2'b00}, // R6 detach
        {1'b0, 4'd0, 16'h0000, 2'b00, 2'b00, 2'b01, 16'h030A, 16'h0003, 2'b00, 2'b00}, // R6 empty detach
        {1'b1, 4'd0, 16'h000A, 2'b01, 2'b00, 2'b00, 16'h0003, 16'h0003, 2'b00, 2'b00}, // R8 collide
        {1'b1, 4'd1, 16'h0004, 2'b00, 2'b00, 2'b00, 16'h0003, 16'h0007, 2'b00, 2'b10}, // R10 enable p1
        {1'b0, 4'd0, 16'h0000, 2'b10, 2'b10, 2'b00, 16'h0003, 16'h010B, 2'b00, 2'b00}, // R7 reattach
        {1'b1, 4'd1, 16'h000A, 2'b00, 2'b00, 2'b00, 16'h0003, 16'h0101, 2'b00, 2'b00}, // R3 clear both
        {1'b1, 4'd1, 16'hF404, 2'b00, 2'b00, 2'b00, 16'h0003, 16'hF505, 2'b00, 2'b10}  // R2 upper bits
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int idx, output logic [15:0] v);
        rd_idx = IW'(idx);
        #1;
        v = rd_data;
    endtask

    task automatic idle();
        ctrl_reset = 0; wr_en = 0; wr_idx = '0; wr_data = '0;
        dev_attach = '0; dev_low_speed = '0; dev_detach = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic check_words(input string tag, input logic [15:0] e0, input logic [15:0] e1);
        logic [15:0] v;
        rd(0, v); chk({tag, " port0"}, v, e0);
        rd(1, v); chk({tag, " port1"}, v, e1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        idle();
        rd_idx = '0;
        rst_n  = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check_words("R1 reset", 16'h0000, 16'h0000);
        chk("R1 outputs", {8'h00, bus_reset_req, port_connected, port_enabled, port_forward}, 16'h0000);

        for (int k = 0; k < NVEC; k++) begin
            logic [62:0] t;
            logic [15:0] e0, e1;
            t = VEC[k];
            wr_en = t[62]; wr_idx = t[61:58]; wr_data = t[57:42];
            dev_attach = t[41:40]; dev_low_speed = t[39:38]; dev_detach = t[37:36];
            e0 = t[35:20]; e1 = t[19:4];
            tick();
            check_words($sformatf("vec%0d R2/R3/R5/R6/R7/R8", k), e0, e1);
            chk($sformatf("vec%0d R4 reset pulse", k), {14'd0, bus_reset_req}, {14'd0, t[3:2]});
            chk($sformatf("vec%0d R10 forward", k), {14'd0, port_forward}, {14'd0, t[1:0]});
            chk($sformatf("vec%0d R10 connected", k), {14'd0, port_connected}, {14'd0, e1[0], e0[0]});
            chk($sformatf("vec%0d R10 enabled", k), {14'd0, port_enabled}, {14'd0, e1[2], e0[2]});
        end

        // R11 controller reset replays attach; same-cycle write with reset bit dropped
        ctrl_reset = 1; wr_en = 1; wr_idx = 4'd1; wr_data = 16'h0204;
        tick();
        check_words("R11 replay", 16'h0003, 16'h0103);
        chk("R11 no pulse", {14'd0, bus_reset_req}, 16'h0000);
        chk("R11 forward off", {14'd0, port_forward}, 16'h0000);

        // R9 out-of-range reads
        rd(2, v);  chk("R9 index 2", v, 16'hFF7F);
        rd(15, v); chk("R9 index 15", v, 16'hFF7F);

        // R6 detach port1, then R4 reset bit on empty port gives no pulse
        dev_detach = 2'b10;
        tick();
        check_words("R6 detach p1", 16'h0003, 16'h0102);
        wr_en = 1; wr_idx = 4'd1; wr_data = 16'h0200;
        tick();
        check_words("R4 empty port write", 16'h0003, 16'h0302);
        chk("R4 empty port no pulse", {14'd0, bus_reset_req}, 16'h0000);

        // R11 controller reset with port1 empty
        ctrl_reset = 1;
        tick();
        check_words("R11 empty port cleared", 16'h0003, 16'h0000);

        // R1 hardware reset mid-run
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_words("R1 second reset", 16'h0000, 16'h0000);
        chk("R1 connected after reset", {14'd0, port_connected}, 16'h0000);

        // R11 after hardware reset nothing is replayed
        ctrl_reset = 1;
        tick();
        check_words("R11 nothing present", 16'h0000, 16'h0000);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule